// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight binary lock flags shared between a left and a right requester. Each side reaches the bank through its own select, write strobe, output enable, 3-bit flag address and single write-data bit, and reads back a 16-bit word. A side asks for a flag by writing 0 and gives it up by writing 1. A read shows whether that side currently holds the flag.

Flags are active low. The side that holds a lock reads all zeros. The other side, or both sides when the lock is free, reads all ones. A request that arrives while the other side holds the lock is not lost. It stays latched, and the lock passes to the waiting side in the same clock edge at which the holder releases it. When both sides ask for a free lock in the same cycle, the left side gets it. The block is synchronous to one clock and uses an active-low asynchronous reset.

A read starts on the first cycle in which select and output enable are high and the write strobe is low. The flag value is captured at that edge and shown on the read bus from the next cycle on. It stays frozen for as long as the read condition holds, even if the lock changes hands in the meantime.

Top module: `sema_bank`

## Requirements
- R1: The bank has eight independent locks, addressed by the 3-bit address of each side. An operation on one lock never changes what another lock reads.
- R2: A write (select high and write strobe high at a clock edge) stores the write-data bit in the writing side's request latch for the addressed lock: 0 asks for the lock and 1 gives it up or withdraws a request.
- R3: A read shows 0 to the side that holds the lock and 1 to the other side. A free lock reads 1 from both sides.
- R4: A request from the side that does not hold the lock changes no read value while the holder keeps the lock.
- R5: When the holder writes 1 while the other side's request is latched, the other side holds the lock from the next cycle. It keeps it until it writes 1 itself.
- R6: A side that writes 1 while its request is still waiting withdraws the request, so a later release by the holder leaves the lock free.
- R7: The read bus carries the same flag value on all 16 bits. It is all zeros on every cycle that follows a clock edge with no read active on that side.
- R8: A read is active while select and output enable are high and the write strobe is low. The value is taken at the first edge of an active read and stays unchanged until the read ends, whatever happens to the lock meanwhile.
- R9: A request for a free lock wins over a later request from the other side. When both sides ask for a free lock at the same edge, the left side wins.
- R10: After reset, every request latch holds 1 and every lock reads free (all ones) from both sides. Both read buses are zero while no read is active.

Port list: clk, rst_n, then the left group (l_sel, l_wr, l_oe, l_addr, l_wbit, l_rdata), then the right group with the same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left side selects the lock bank |
| l_wr | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | 3 | Left lock address |
| l_wbit | input | 1 | Left write data (0 = request, 1 = release) |
| l_rdata | output | 16 | Left read bus, flag replicated on all bits |
| r_sel | input | 1 | Right side selects the lock bank |
| r_wr | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | 3 | Right lock address |
| r_wbit | input | 1 | Right write data (0 = request, 1 = release) |
| r_rdata | output | 16 | Right read bus, flag replicated on all bits |

## Verification
A wrong owner or a lost request latch shows up on the next read of that lock from either side. It appears one cycle after the read starts, as a zero word on the wrong side or as ones on both sides where one side should read zero. A dropped or spurious handoff appears on the first read after the release edge. A broken capture register shows as a word that changes during a held read, or as a non-zero bus on an idle cycle. The bench compares every cycle of both read buses against its own model, so a state fault is reported at the first read that reaches the lock concerned.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  // Next holder from the current holder and the updated request latches
  // (latches are active low: 0 = request pending or held).
  function automatic owner_t next_owner(owner_t cur, logic lreq_n, logic rreq_n);
    owner_t nxt;
    case (cur)
      OWN_LEFT:  nxt = !lreq_n ? OWN_LEFT  : (!rreq_n ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: nxt = !rreq_n ? OWN_RIGHT : (!lreq_n ? OWN_LEFT  : OWN_NONE);
      default:   nxt = !lreq_n ? OWN_LEFT  : (!rreq_n ? OWN_RIGHT : OWN_NONE);
    endcase
    return nxt;
  endfunction

  // Active-low flag as seen from one side (is_right selects the viewer).
  function automatic logic side_flag(owner_t cur, logic is_right);
    return is_right ? (cur != OWN_RIGHT) : (cur != OWN_LEFT);
  endfunction

endpackage

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_we,
  input  logic l_bit,
  input  logic r_we,
  input  logic r_bit,
  output logic l_flag,
  output logic r_flag
);

  logic   l_req_q, r_req_q;
  logic   l_req_d, r_req_d;
  owner_t owner_q, owner_d;

  // named events for the assertions
  logic l_release, r_release, l_ask, r_ask;

  assign l_release = l_we &&  l_bit;
  assign r_release = r_we &&  r_bit;
  assign l_ask     = l_we && !l_bit;
  assign r_ask     = r_we && !r_bit;

  assign l_req_d = l_we ? l_bit : l_req_q;
  assign r_req_d = r_we ? r_bit : r_req_q;
  assign owner_d = next_owner(owner_q, l_req_d, r_req_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_req_q <= 1'b1;
      r_req_q <= 1'b1;
      owner_q <= OWN_NONE;
    end else begin
      l_req_q <= l_req_d;
      r_req_q <= r_req_d;
      owner_q <= owner_d;
    end
  end

  assign l_flag = side_flag(owner_q, 1'b0);
  assign r_flag = side_flag(owner_q, 1'b1);

  // R9: simultaneous requests on a free lock go to the left side
  assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && l_ask && r_ask) |=> owner_q == OWN_LEFT);

  // R9: a free lock asked for by the right side alone goes right
  assert_first_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && r_ask && !l_ask) |=> owner_q == OWN_RIGHT);

  // R5: release with the other request latched hands the lock over
  assert_handoff_lr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && l_release && !r_req_q && !r_release) |=> owner_q == OWN_RIGHT);
  assert_handoff_rl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RIGHT && r_release && !l_req_q && !l_release) |=> owner_q == OWN_LEFT);

  // R4: the holder keeps the lock until it writes 1
  assert_hold_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && !l_release) |=> owner_q == OWN_LEFT);
  assert_hold_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RIGHT && !r_release) |=> owner_q == OWN_RIGHT);

  // R3: a free lock has no request left waiting on either side
  assert_free_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE) |-> (l_req_q && r_req_q));

endmodule

// File: rtl/sema_port.sv
module sema_port #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 16,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic               oe,
  input  logic [SEL_W-1:0]   addr,
  input  logic [NUM_SEM-1:0] flags,
  output logic [NUM_SEM-1:0] we_vec,
  output logic [RD_W-1:0]    rdata
);

  logic wr_act, rd_act, rd_act_q, rd_start;
  logic flag_sel;
  logic rd_bit_q, rd_valid_q;

  assign wr_act   = sel && wr;
  assign rd_act   = sel && oe && !wr;
  assign rd_start = rd_act && !rd_act_q;
  assign flag_sel = flags[addr];

  for (genvar j = 0; j < NUM_SEM; j++) begin : g_dec
    assign we_vec[j] = wr_act && (addr == SEL_W'(j));
  end

  // one stored bit per side; replicated onto the bus at the output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q   <= 1'b0;
      rd_bit_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_start) begin
        rd_bit_q   <= flag_sel;
        rd_valid_q <= 1'b1;
      end else if (!rd_act) begin
        rd_valid_q <= 1'b0;
      end
    end
  end

  assign rdata = rd_valid_q ? {RD_W{rd_bit_q}} : '0;

  // R2: a write strobe reaches a lock only from a selected write cycle
  assert_write_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_vec != '0) |-> (sel && wr));

  // R8: a started read shows the flag present at its first edge
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> rdata == {RD_W{$past(flag_sel)}});

  // R8: the value is frozen while the read continues
  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_act_q) |=> $stable(rdata));

  // R7: no read, zero bus on the following cycle
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> rdata == '0);

  // R7: every bit of the bus carries the same value
  assert_replicate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1));

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 16,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l_sel,
  input  logic             l_wr,
  input  logic             l_oe,
  input  logic [SEL_W-1:0] l_addr,
  input  logic             l_wbit,
  output logic [RD_W-1:0]  l_rdata,
  input  logic             r_sel,
  input  logic             r_wr,
  input  logic             r_oe,
  input  logic [SEL_W-1:0] r_addr,
  input  logic             r_wbit,
  output logic [RD_W-1:0]  r_rdata
);

  localparam int SIDES = 2;

  logic [SIDES-1:0]              side_sel, side_wr, side_oe, side_bit;
  logic [SIDES-1:0][SEL_W-1:0]   side_addr;
  logic [SIDES-1:0][NUM_SEM-1:0] side_we;
  logic [SIDES-1:0][NUM_SEM-1:0] side_flags;
  logic [SIDES-1:0][RD_W-1:0]    side_rdata;

  assign side_sel  = {r_sel,  l_sel};
  assign side_wr   = {r_wr,   l_wr};
  assign side_oe   = {r_oe,   l_oe};
  assign side_bit  = {r_wbit, l_wbit};
  assign side_addr = {r_addr, l_addr};

  for (genvar p = 0; p < SIDES; p++) begin : g_side
    sema_port #(
      .NUM_SEM (NUM_SEM),
      .RD_W    (RD_W)
    ) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (side_sel[p]),
      .wr     (side_wr[p]),
      .oe     (side_oe[p]),
      .addr   (side_addr[p]),
      .flags  (side_flags[p]),
      .we_vec (side_we[p]),
      .rdata  (side_rdata[p])
    );
  end

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sema_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_we   (side_we[0][i]),
      .l_bit  (side_bit[0]),
      .r_we   (side_we[1][i]),
      .r_bit  (side_bit[1]),
      .l_flag (side_flags[0][i]),
      .r_flag (side_flags[1][i])
    );
  end

  assign l_rdata = side_rdata[0];
  assign r_rdata = side_rdata[1];

  // R1: a write from one side strobes at most one lock
  assert_one_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(side_we[0]) && $onehot0(side_we[1]));

  // R3: no lock is ever seen as held by both sides
  assert_single_holder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (side_flags[0] | side_flags[1]) == '1);

endmodule

// File: tb/sema_bank_tb.sv
module sema_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSEM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_sel = 0, l_wr = 0, l_oe = 0, l_wbit = 0;
  logic [2:0]  l_addr = '0;
  logic        r_sel = 0, r_wr = 0, r_oe = 0, r_wbit = 0;
  logic [2:0]  r_addr = '0;
  logic [15:0] l_rdata, r_rdata;

  int checks = 0;
  int fails  = 0;

  // model: holder 0 = free, 1 = left, 2 = right; request latches active low
  int m_own [NSEM];
  bit m_lreq [NSEM];
  bit m_rreq [NSEM];
  bit m_lact, m_ract;
  logic [15:0] m_lexp, m_rexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  function automatic bit mflag(int s, bit right);
    if (right) return m_own[s] != 2;
    return m_own[s] != 1;
  endfunction

  function automatic int mnext(int own, bit lq, bit rq);
    if (own == 1 && lq == 1'b0) return 1;
    if (own == 2 && rq == 1'b0) return 2;
    if (own == 1) return (rq == 1'b0) ? 2 : 0;
    if (own == 2) return (lq == 1'b0) ? 1 : 0;
    if (lq == 1'b0) return 1;
    if (rq == 1'b0) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic step(string tag, int lop, int la, bit lb, int rop, int ra, bit rb);
    logic [15:0] el, er;
    bit la_act, ra_act;
    la_act = (lop == 2);
    ra_act = (rop == 2);
    l_sel = (lop != 0); l_wr = (lop == 1); l_oe = la_act ? 1'b1 : 1'($urandom % 2);
    l_addr = 3'(la); l_wbit = lb;
    r_sel = (rop != 0); r_wr = (rop == 1); r_oe = ra_act ? 1'b1 : 1'($urandom % 2);
    r_addr = 3'(ra); r_wbit = rb;
    el = !la_act ? 16'h0 : (!m_lact ? {16{mflag(la, 1'b0)}} : m_lexp);
    er = !ra_act ? 16'h0 : (!m_ract ? {16{mflag(ra, 1'b1)}} : m_rexp);
    if (lop == 1) m_lreq[la] = lb;
    if (rop == 1) m_rreq[ra] = rb;
    for (int s = 0; s < NSEM; s++) m_own[s] = mnext(m_own[s], m_lreq[s], m_rreq[s]);
    m_lact = la_act; m_ract = ra_act; m_lexp = el; m_rexp = er;
    @(posedge clk); #1;
    chk({tag, " left"}, l_rdata, el);
    chk({tag, " right"}, r_rdata, er);
    @(negedge clk);
  endtask

  task automatic idle();
    step("R7 idle", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int s = 0; s < NSEM; s++) begin m_own[s] = 0; m_lreq[s] = 1; m_rreq[s] = 1; end
    m_lact = 0; m_ract = 0; m_lexp = 0; m_rexp = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset left", l_rdata, 16'h0000);
    chk("R10 reset right", r_rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: every lock free after reset
    for (int s = 0; s < NSEM; s++) begin
      step("R10 free", 2, s, 0, 2, s, 0);
      chk("R10 free left", l_rdata, 16'hFFFF);
      chk("R10 free right", r_rdata, 16'hFFFF);
      idle();
      chk("R7 idle zero", l_rdata, 16'h0000);
    end

    // R2/R3: left takes lock 3
    step("R2 request", 1, 3, 0, 0, 0, 0);
    step("R3 read", 2, 3, 0, 2, 3, 0);
    chk("R3 holder left", l_rdata, 16'h0000);
    chk("R3 other right", r_rdata, 16'hFFFF);
    idle();
    // R1: neighbouring lock untouched
    step("R1 other lock", 2, 2, 0, 2, 4, 0);
    chk("R1 lock2 left", l_rdata, 16'hFFFF);
    chk("R1 lock4 right", r_rdata, 16'hFFFF);
    idle();

    // R4: right waits on lock 3
    step("R4 pending", 0, 0, 0, 1, 3, 0);
    step("R4 read", 2, 3, 0, 2, 3, 0);
    chk("R4 left still holds", l_rdata, 16'h0000);
    chk("R4 right still out", r_rdata, 16'hFFFF);
    idle();

    // R5: release hands over
    step("R5 release", 1, 3, 1, 0, 0, 0);
    step("R5 read", 2, 3, 0, 2, 3, 0);
    chk("R5 left out", l_rdata, 16'hFFFF);
    chk("R5 right holds", r_rdata, 16'h0000);
    idle();

    // R6: left asks, withdraws, right releases -> free
    step("R6 ask", 1, 3, 0, 0, 0, 0);
    step("R6 withdraw", 1, 3, 1, 0, 0, 0);
    step("R6 release", 0, 0, 0, 1, 3, 1);
    step("R6 read", 2, 3, 0, 2, 3, 0);
    chk("R6 left free", l_rdata, 16'hFFFF);
    chk("R6 right free", r_rdata, 16'hFFFF);
    idle();

    // R9: tie goes left
    step("R9 tie", 1, 5, 0, 1, 5, 0);
    step("R9 tie read", 2, 5, 0, 2, 5, 0);
    chk("R9 tie left wins", l_rdata, 16'h0000);
    chk("R9 tie right loses", r_rdata, 16'hFFFF);
    idle();
    step("R9 left release", 1, 5, 1, 0, 0, 0);
    step("R9 right withdraw", 0, 0, 0, 1, 5, 1);

    // R9: earlier requester (right) wins
    step("R9 right first", 0, 0, 0, 1, 1, 0);
    step("R9 left later", 1, 1, 0, 0, 0, 0);
    step("R9 order read", 2, 1, 0, 2, 1, 0);
    chk("R9 order left", l_rdata, 16'hFFFF);
    chk("R9 order right", r_rdata, 16'h0000);
    idle();
    step("R9 right release", 0, 0, 0, 1, 1, 1);
    step("R9 left release", 1, 1, 1, 0, 0, 0);

    // R8: frozen read across a handoff
    step("R8 left takes", 1, 6, 0, 0, 0, 0);
    step("R8 right waits", 0, 0, 0, 1, 6, 0);
    step("R8 read start", 0, 0, 0, 2, 6, 0);
    chk("R8 captured", r_rdata, 16'hFFFF);
    step("R8 handoff during read", 1, 6, 1, 2, 6, 0);
    step("R8 still reading", 0, 0, 0, 2, 6, 0);
    chk("R8 frozen", r_rdata, 16'hFFFF);
    idle();
    chk("R7 end of read", r_rdata, 16'h0000);
    step("R8 new read", 0, 0, 0, 2, 6, 0);
    chk("R8 fresh value", r_rdata, 16'h0000);
    idle();
    step("R8 cleanup", 0, 0, 0, 1, 6, 1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      step("R1-R9 random", int'($urandom % 3), int'($urandom % NSEM), 1'($urandom % 2),
           int'($urandom % 3), int'($urandom % NSEM), 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule